// File: doc/BRIEF.md
# Floating-Point Exception Status Recorder

This block sits behind a floating-point datapath and folds the exception flags that an operation raised into the exception fields of the floating-point status word. Each time the datapath presents a completed operation with a valid strobe, the block takes the five raw flags and the current status word. It decides whether any raised flag is enabled for trapping and registers an updated status word one clock later, together with exactly one of two single-cycle pulses. The trap pulse asks the core to take an IEEE exception trap. The pc-advance pulse tells the core to move on: the next pc takes the old next-pc, and the next-pc grows by 4.

When a trap is taken, the flags are first masked by the trap enables and then reduced to a single flag by fixed priority, so the current-exception field always names one cause. The accrued field is left alone and the trap-type field is set to the IEEE-exception code. When no trap is taken, the raw flags become the current-exception field and are also ORed into the accrued field. Bits of the status word outside these fields pass through unchanged. Between strobes the registered status word holds its value.

Top module: `fpx_status_recorder`

## Requirements
- R1: While reset is asserted, and until it is released, stat_out is all zeros and trap_req and pc_adv are 0.
- R2: A trap is taken for a strobed operation exactly when op_flags AND the enable mask stat_in[27:23] is nonzero. One clock after the strobe, trap_req pulses for one cycle if a trap is taken, and pc_adv pulses for one cycle otherwise. The two never pulse together.
- R3: On a trap, the current-exception field stat_out[4:0] holds only the highest-priority bit of the enabled flags. Flag encoding and priority, highest first: invalid bit 4, overflow bit 3, underflow bit 2, divide-by-zero bit 1, inexact bit 0.
- R4: Without a trap, stat_out[4:0] is replaced by op_flags exactly, whatever stat_in[4:0] held.
- R5: Without a trap, the accrued field stat_out[9:5] equals stat_in[9:5] OR op_flags. On a trap it equals stat_in[9:5].
- R6: On a trap, the trap-type field stat_out[16:14] is 3'b001. Without a trap it equals stat_in[16:14].
- R7: An operation with op_flags of zero gives stat_out[4:0] = 0, leaves stat_out[9:5] equal to stat_in[9:5], and pulses pc_adv.
- R8: All status bits outside fields [4:0], [9:5] and [16:14], including the enable mask, are copied from stat_in.
- R9: In a cycle without op_valid, stat_out keeps its previous value whatever stat_in and op_flags carry, and neither pulse fires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Strobe: an operation completed this cycle |
| op_flags | input | 5 | Raw exception flags from the datapath |
| stat_in | input | STAT_W | Current status word |
| stat_out | output | STAT_W | Registered updated status word |
| trap_req | output | 1 | One-cycle IEEE exception trap request |
| pc_adv | output | 1 | One-cycle request to advance the pc |

## Verification
The bench goes after operations where several flags are raised but only some are enabled. A design that reduces before masking, or that picks the wrong priority, would report an unenabled or lower-ranked cause in the current field. It also covers flags raised with every enable cleared, and zero flags with enables set. Here a design that traps on any flag would pulse the wrong output, and one that merges the accrued field on a trap would leak causes into it. Stale values planted in the incoming current and trap-type fields, and garbage driven between strobes, expose designs that OR the current field instead of replacing it, that rewrite the trap type without a trap, or that update while idle.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int NFLAG     = 5;
  localparam int CUR_LSB   = 0;
  localparam int ACC_LSB   = 5;
  localparam int TTYPE_LSB = 14;
  localparam int TTYPE_W   = 3;
  localparam int ENA_LSB   = 23;
  localparam int MIN_STAT_W = ENA_LSB + NFLAG;
  localparam logic [TTYPE_W-1:0] TTYPE_IEEE = 3'd1;

  typedef logic [NFLAG-1:0] flags_t;
endpackage

// File: rtl/fpx_rst_sync.sv
module fpx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fpx_trap_eval.sv
module fpx_trap_eval
  import fpx_pkg::*;
(
  input  flags_t raw_flags,
  input  flags_t enables,
  output logic   take_trap,
  output flags_t single_flag
);
  flags_t masked;
  flags_t seen_above;

  assign masked    = raw_flags & enables;
  assign take_trap = |masked;

  // Highest bit wins: invalid (4) down to inexact (0).
  generate
    for (genvar i = NFLAG - 1; i >= 0; i--) begin : g_prio
      if (i == NFLAG - 1) begin : g_top
        assign seen_above[i] = 1'b0;
      end else begin : g_rest
        assign seen_above[i] = seen_above[i+1] | masked[i+1];
      end
      assign single_flag[i] = masked[i] & ~seen_above[i];
    end
  endgenerate
endmodule

// File: rtl/fpx_field_merge.sv
module fpx_field_merge
  import fpx_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input  logic [STAT_W-1:0] stat_in,
  input  flags_t            raw_flags,
  input  logic              take_trap,
  input  flags_t            single_flag,
  output logic [STAT_W-1:0] stat_next
);
  flags_t cur_new;
  flags_t acc_old;

  assign acc_old = stat_in[ACC_LSB +: NFLAG];
  assign cur_new = take_trap ? single_flag : raw_flags;

  always_comb begin
    stat_next = stat_in;
    stat_next[CUR_LSB +: NFLAG] = cur_new;
    if (take_trap) begin
      stat_next[TTYPE_LSB +: TTYPE_W] = TTYPE_IEEE;
    end else begin
      stat_next[ACC_LSB +: NFLAG] = acc_old | raw_flags;
    end
  end
endmodule

// File: rtl/fpx_status_recorder.sv
module fpx_status_recorder
  import fpx_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [NFLAG-1:0]  op_flags,
  input  logic [STAT_W-1:0] stat_in,
  output logic [STAT_W-1:0] stat_out,
  output logic              trap_req,
  output logic              pc_adv
);
  logic              rst_sync_n;
  logic              take_trap;
  flags_t            single_flag;
  logic [STAT_W-1:0] stat_next;

  logic [STAT_W-1:0] stat_q, stat_d;
  logic              trap_q, trap_d;
  logic              adv_q, adv_d;

  fpx_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fpx_trap_eval u_trap_eval (
    .raw_flags   (op_flags),
    .enables     (stat_in[ENA_LSB +: NFLAG]),
    .take_trap   (take_trap),
    .single_flag (single_flag)
  );

  fpx_field_merge #(.STAT_W(STAT_W)) u_field_merge (
    .stat_in     (stat_in),
    .raw_flags   (op_flags),
    .take_trap   (take_trap),
    .single_flag (single_flag),
    .stat_next   (stat_next)
  );

  always_comb begin
    stat_d = stat_q;
    trap_d = 1'b0;
    adv_d  = 1'b0;
    if (op_valid) begin
      stat_d = stat_next;
      trap_d = take_trap;
      adv_d  = ~take_trap;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      stat_q <= '0;
      trap_q <= 1'b0;
      adv_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      trap_q <= trap_d;
      adv_q  <= adv_d;
    end
  end

  assign stat_out = stat_q;
  assign trap_req = trap_q;
  assign pc_adv   = adv_q;

  initial begin
    assert (STAT_W >= MIN_STAT_W) else $error("STAT_W too small for field layout");
  end

  assert_pulse_excl_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(trap_req && pc_adv));

  assert_pulse_needs_strobe_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$past(op_valid) |-> (!trap_req && !pc_adv && $stable(stat_out)));

  assert_single_cause_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trap_req |-> $onehot0(stat_out[CUR_LSB +: NFLAG]) && (stat_out[CUR_LSB +: NFLAG] != '0));

  assert_trap_type_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trap_req |-> stat_out[TTYPE_LSB +: TTYPE_W] == TTYPE_IEEE);

  assert_accrued_merge_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pc_adv |-> stat_out[ACC_LSB +: NFLAG] ==
               ($past(stat_in[ACC_LSB +: NFLAG]) | $past(op_flags)));

  assert_accrued_kept_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trap_req |-> stat_out[ACC_LSB +: NFLAG] == $past(stat_in[ACC_LSB +: NFLAG]));

  assert_cur_replaced_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pc_adv |-> stat_out[CUR_LSB +: NFLAG] == $past(op_flags));
endmodule

// File: tb/fpx_status_recorder_bench.sv
module fpx_status_recorder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int STAT_W = 32;
  localparam int NVEC = 10;

  // {flags, enables, acc_in, exp_trap, exp_cur, exp_acc}
  localparam logic [25:0] VEC [NVEC] = '{
    {5'b00000, 5'b11111, 5'b00101, 1'b0, 5'b00000, 5'b00101}, // R7
    {5'b00001, 5'b00000, 5'b00000, 1'b0, 5'b00001, 5'b00001}, // R4
    {5'b11111, 5'b00000, 5'b00010, 1'b0, 5'b11111, 5'b11111}, // R4 R5
    {5'b11111, 5'b11111, 5'b00000, 1'b1, 5'b10000, 5'b00000}, // R3
    {5'b01110, 5'b00110, 5'b00001, 1'b1, 5'b00100, 5'b00001}, // R3
    {5'b01011, 5'b00011, 5'b10000, 1'b1, 5'b00010, 5'b10000}, // R3
    {5'b00001, 5'b00001, 5'b00000, 1'b1, 5'b00001, 5'b00000}, // R2
    {5'b01010, 5'b10101, 5'b00100, 1'b0, 5'b01010, 5'b01110}, // R2
    {5'b11000, 5'b01000, 5'b00000, 1'b1, 5'b01000, 5'b00000}, // R3
    {5'b00110, 5'b00100, 5'b11111, 1'b1, 5'b00100, 5'b11111}  // R5
  };

  logic              clk;
  logic              rst_n;
  logic              op_valid;
  logic [4:0]        op_flags;
  logic [STAT_W-1:0] stat_in;
  logic [STAT_W-1:0] stat_out;
  logic              trap_req;
  logic              pc_adv;

  int checks;
  int failures;

  fpx_status_recorder #(.STAT_W(STAT_W)) u_fpx_status_recorder (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_flags (op_flags),
    .stat_in  (stat_in),
    .stat_out (stat_out),
    .trap_req (trap_req),
    .pc_adv   (pc_adv)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [STAT_W-1:0] act,
                       input logic [STAT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [STAT_W-1:0] build(input logic [4:0] ena,
      input logic [2:0] tt, input logic [4:0] acc, input logic [4:0] cur);
    return {4'hC, ena, 6'h15, tt, 4'h3, acc, cur};
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0;
    failures = 0;
    rst_n = 1'b0;
    op_valid = 1'b0;
    op_flags = '0;
    stat_in = '1;
    repeat (3) @(negedge clk);
    check("R1 stat_out", stat_out, '0);
    check("R1 trap_req", 32'(trap_req), 32'd0);
    check("R1 pc_adv", 32'(pc_adv), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", stat_out, '0);

    for (int i = 0; i < NVEC; i++) begin
      logic [4:0] fl, en, ai, ec, ea;
      logic et;
      logic [2:0] tt;
      logic [STAT_W-1:0] exp_stat;
      {fl, en, ai, et, ec, ea} = VEC[i];
      tt = 3'(i + 2);
      op_valid = 1'b1;
      op_flags = fl;
      stat_in  = build(en, tt, ai, 5'b10101);
      exp_stat = build(en, et ? 3'd1 : tt, ea, ec);
      @(negedge clk);
      op_valid = 1'b0;
      op_flags = 5'b11111;
      stat_in  = ~stat_in;
      check($sformatf("R8 R6 R4 R3 vec%0d stat_out", i), stat_out, exp_stat);
      check($sformatf("R2 vec%0d trap_req", i), 32'(trap_req), 32'(et));
      check($sformatf("R2 vec%0d pc_adv", i), 32'(pc_adv), 32'(!et));
      @(negedge clk);
      check($sformatf("R9 vec%0d hold", i), stat_out, exp_stat);
      check($sformatf("R9 vec%0d no pulse", i), 32'({trap_req, pc_adv}), 32'd0);
    end

    // Reset mid-run clears the recorded state (R1)
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset", stat_out, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Back-to-back strobes: second one with zero flags (R7)
    op_valid = 1'b1;
    op_flags = 5'b00100;
    stat_in  = build(5'b00000, 3'd0, 5'b00000, 5'b00000);
    @(negedge clk);
    check("R5 back-to-back first", stat_out, build(5'b00000, 3'd0, 5'b00100, 5'b00100));
    op_flags = 5'b00000;
    stat_in  = build(5'b11111, 3'd5, 5'b01001, 5'b11111);
    @(negedge clk);
    op_valid = 1'b0;
    check("R7 zero flags", stat_out, build(5'b11111, 3'd5, 5'b01001, 5'b00000));
    check("R7 pc_adv", 32'(pc_adv), 32'd1);
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule